// File: doc/BRIEF.md
# Fixed Off-Time Current Chopper

This block keeps the phase current of a three-phase motor bridge near a set level. It chops the drive at a fixed off time. A digital comparator input goes high when the sensed current exceeds the reference. While the bridge is driving, that input ends the drive period: the sink-leg low-side switch opens and an off-time timer starts. The current then decays slowly through the upper half of the bridge. After a dead time, the sink-leg high-side switch closes to give synchronous recirculation. When the timer expires, that switch opens again. After a second dead time, the low-side switch closes and a new drive period begins.

Each drive period starts with a blanking window, during which the comparator is not looked at. This keeps the reverse-recovery spike of the diodes from re-triggering the timer. A minimum drive length is also enforced. A trip that arrives after blanking but before the minimum length is held and acted on once the minimum is reached. The block produces high-side and low-side enables for the two active legs: the source leg and the sink leg. The off time, dead time, blanking window and minimum on time are all counted in clock cycles. Taking the enable input low turns every gate off at once and returns the block to idle.

Top module: `cot_chopper`

## Requirements
- R1: While reset is asserted, or while enable is low, all four gate enables and chop_active are 0.
- R2: One clock after enable rises from idle, the drive pattern is present: src_hi=1, snk_lo=1, snk_hi=0, src_lo=0. The source-leg low side is never enabled.
- R3: Once blanking and minimum on time are satisfied, a high sense_over sampled during a drive cycle opens snk_lo at the next clock. src_hi stays on and chop_active goes to 1.
- R4: sense_over is ignored during the first T_BLANK cycles of every drive period. A pulse there does not shorten the drive.
- R5: A drive period lasts at least T_MINON cycles. A trip seen after blanking but before that length is held, and ends the drive at exactly T_MINON cycles.
- R6: After a trip, snk_hi stays off for T_DEAD cycles. It is then on for T_OFF-T_DEAD cycles, counted so that its turn-off lands T_OFF cycles after the trip.
- R7: After snk_hi turns off, snk_hi and snk_lo are both off for T_DEAD cycles. Then snk_lo returns, so the low side is off for exactly T_OFF+T_DEAD cycles per chop.
- R8: chop_active is 1 exactly while the low side is held off by a chop (from the trip until snk_lo is re-enabled). It is 0 during drive.
- R9: When enable goes low, all gate enables and chop_active drop in the same cycle, without waiting for a clock, and the block returns to idle. A later enable starts a new drive period with a full blanking window.
- R10: snk_hi and snk_lo are never both 1.
- R11: sense_over is ignored during the off sequence. It neither restarts nor stretches the off time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Bridge enable; low forces all gates off and idles the chopper |
| sense_over | input | 1 | Comparator output, 1 when sensed current exceeds the reference |
| src_hi | output | 1 | Source-leg high-side gate enable |
| src_lo | output | 1 | Source-leg low-side gate enable (held off) |
| snk_hi | output | 1 | Sink-leg high-side gate enable (synchronous recirculation) |
| snk_lo | output | 1 | Sink-leg low-side gate enable (chopped switch) |
| chop_active | output | 1 | High from a trip until the low side is re-enabled |

## Verification
Two of the block's functions can fall in the same cycle, and both cases are provoked deliberately.

The first is a comparator trip arriving in the cycle where blanking opens, or where the minimum on time is reached. Single-cycle and held pulses are placed exactly on those cycle indices. The result is judged by how many cycles snk_lo stays high.

The second is enable falling in the same cycle as a trip. Enable must win: the bench samples the gate outputs one time step after driving both inputs together and expects all of them low. It then checks that the next drive period runs with full blanking.

// File: rtl/cot_chopper_pkg.sv
package cot_chopper_pkg;

  typedef enum logic [2:0] {
    PH_IDLE   = 3'd0,
    PH_DRIVE  = 3'd1,
    PH_GAP_A  = 3'd2,
    PH_RECIRC = 3'd3,
    PH_GAP_B  = 3'd4
  } phase_t;

  typedef struct packed {
    logic src_hi;
    logic src_lo;
    logic snk_hi;
    logic snk_lo;
  } gates_t;

  // Gate pattern held in each phase of the chop cycle.
  function automatic gates_t gates_for(phase_t p);
    gates_t g;
    g = '0;
    case (p)
      PH_DRIVE:  begin g.src_hi = 1'b1; g.snk_lo = 1'b1; end
      PH_GAP_A:  g.src_hi = 1'b1;
      PH_RECIRC: begin g.src_hi = 1'b1; g.snk_hi = 1'b1; end
      PH_GAP_B:  g.src_hi = 1'b1;
      default:   g = '0;
    endcase
    return g;
  endfunction

  // True in the phases where the low side is held off by a chop.
  function automatic logic in_off_time(phase_t p);
    return (p == PH_GAP_A) || (p == PH_RECIRC) || (p == PH_GAP_B);
  endfunction

  function automatic int unsigned max3(int unsigned a, int unsigned b, int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/cot_tick_counter.sv
module cot_tick_counter #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  output logic [WIDTH-1:0] count
);
  localparam logic [WIDTH-1:0] TOP = '1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            count <= '0;
    else if (clear)        count <= '0;
    else if (count != TOP) count <= count + 1'b1;
  end
endmodule

// File: rtl/cot_phase_fsm.sv
module cot_phase_fsm
  import cot_chopper_pkg::*;
#(
  parameter int T_OFF   = 100,
  parameter int T_DEAD  = 10,
  parameter int T_BLANK = 10,
  parameter int T_MINON = 15,
  parameter int PCW     = 5,
  parameter int MCW     = 7
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           enable,
  input  logic           sense_over,
  input  logic [PCW-1:0] ph_cnt,
  input  logic [MCW-1:0] mono_cnt,
  output phase_t         phase,
  output phase_t         phase_nxt,
  output logic           fire,
  output logic           blank_open,
  output logic           minon_ok,
  output logic           mono_done,
  output logic           gap_done
);
  localparam logic [PCW-1:0] BLANK_C = PCW'(T_BLANK);
  localparam logic [PCW-1:0] MINON_C = PCW'(T_MINON - 1);
  localparam logic [PCW-1:0] DEAD_C  = PCW'(T_DEAD - 1);
  localparam logic [MCW-1:0] MONO_C  = MCW'(T_OFF - 1);

  logic pending;
  logic seen;

  assign blank_open = (ph_cnt >= BLANK_C);
  assign minon_ok   = (ph_cnt >= MINON_C);
  assign seen       = sense_over && blank_open;
  assign fire       = (phase == PH_DRIVE) && minon_ok && (pending || seen);
  assign gap_done   = (ph_cnt == DEAD_C);
  assign mono_done  = (mono_cnt == MONO_C);

  always_comb begin
    phase_nxt = phase;
    if (!enable) phase_nxt = PH_IDLE;
    else begin
      case (phase)
        PH_IDLE:   phase_nxt = PH_DRIVE;
        PH_DRIVE:  if (fire)      phase_nxt = PH_GAP_A;
        PH_GAP_A:  if (gap_done)  phase_nxt = PH_RECIRC;
        PH_RECIRC: if (mono_done) phase_nxt = PH_GAP_B;
        PH_GAP_B:  if (gap_done)  phase_nxt = PH_DRIVE;
        default:   phase_nxt = PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase   <= PH_IDLE;
      pending <= 1'b0;
    end else begin
      phase <= phase_nxt;
      if (phase != PH_DRIVE || phase_nxt != PH_DRIVE) pending <= 1'b0;
      else if (seen)                                  pending <= 1'b1;
    end
  end
endmodule

// File: rtl/cot_gate_map.sv
module cot_gate_map
  import cot_chopper_pkg::*;
(
  input  phase_t phase,
  input  logic   enable,
  output gates_t gates,
  output logic   chop_active
);
  gates_t raw;

  always_comb begin
    raw         = gates_for(phase);
    gates       = enable ? raw : '0;
    chop_active = enable && in_off_time(phase);
  end
endmodule

// File: rtl/cot_chopper.sv
module cot_chopper
  import cot_chopper_pkg::*;
#(
  parameter int T_OFF   = 100,
  parameter int T_DEAD  = 10,
  parameter int T_BLANK = 10,
  parameter int T_MINON = 15
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic sense_over,
  output logic src_hi,
  output logic src_lo,
  output logic snk_hi,
  output logic snk_lo,
  output logic chop_active
);
  localparam int PH_MAX = int'(max3(T_DEAD, T_BLANK, T_MINON));
  localparam int PCW    = $clog2(PH_MAX + 2);
  localparam int MCW    = $clog2(T_OFF + 2);

  phase_t         phase;
  phase_t         phase_nxt;
  logic [PCW-1:0] ph_cnt;
  logic [MCW-1:0] mono_cnt;
  logic           fire;
  logic           blank_open;
  logic           minon_ok;
  logic           mono_done;
  logic           gap_done;
  logic           phase_change;
  gates_t         gates;

  assign phase_change = (phase_nxt != phase);

  cot_tick_counter #(.WIDTH(PCW)) u_phase_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (phase_change),
    .count (ph_cnt)
  );

  cot_tick_counter #(.WIDTH(MCW)) u_mono_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (fire),
    .count (mono_cnt)
  );

  cot_phase_fsm #(
    .T_OFF   (T_OFF),
    .T_DEAD  (T_DEAD),
    .T_BLANK (T_BLANK),
    .T_MINON (T_MINON),
    .PCW     (PCW),
    .MCW     (MCW)
  ) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .enable     (enable),
    .sense_over (sense_over),
    .ph_cnt     (ph_cnt),
    .mono_cnt   (mono_cnt),
    .phase      (phase),
    .phase_nxt  (phase_nxt),
    .fire       (fire),
    .blank_open (blank_open),
    .minon_ok   (minon_ok),
    .mono_done  (mono_done),
    .gap_done   (gap_done)
  );

  cot_gate_map u_map (
    .phase       (phase),
    .enable      (enable),
    .gates       (gates),
    .chop_active (chop_active)
  );

  assign src_hi = gates.src_hi;
  assign src_lo = gates.src_lo;
  assign snk_hi = gates.snk_hi;
  assign snk_lo = gates.snk_lo;
endmodule

// File: rtl/cot_chopper_chk.sv
module cot_chopper_chk #(
  parameter int T_OFF   = 100,
  parameter int T_DEAD  = 10,
  parameter int T_MINON = 15
) (
  input logic clk,
  input logic rst_n,
  input logic enable,
  input logic src_hi,
  input logic src_lo,
  input logic snk_hi,
  input logic snk_lo,
  input logic chop_active,
  input logic fire
);
  int unsigned on_run;
  int unsigned off_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      on_run  <= 0;
      off_run <= 0;
    end else begin
      on_run  <= snk_lo ? on_run + 1 : 0;
      off_run <= (!enable || snk_lo) ? 0 : (chop_active ? off_run + 1 : off_run);
    end
  end

  // R10
  no_shoot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(snk_hi && snk_lo));

  // R9
  gate_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |-> !(src_hi || src_lo || snk_hi || snk_lo || chop_active));

  // R8
  chop_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chop_active |-> !snk_lo && src_hi);

  // R3
  trip_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> !snk_lo);

  // R6
  recirc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    snk_hi |-> chop_active);

  // R2
  start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(enable) |=> !enable || (snk_lo && src_hi && !snk_hi));

  // R5
  min_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(snk_lo) && enable && $past(enable)) |-> on_run >= T_MINON);

  // R7
  off_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(snk_lo) && $past(chop_active)) |-> off_run == T_OFF + T_DEAD);
endmodule

bind cot_chopper cot_chopper_chk #(
  .T_OFF   (T_OFF),
  .T_DEAD  (T_DEAD),
  .T_MINON (T_MINON)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .enable      (enable),
  .src_hi      (src_hi),
  .src_lo      (src_lo),
  .snk_hi      (snk_hi),
  .snk_lo      (snk_lo),
  .chop_active (chop_active),
  .fire        (fire)
);

// File: tb/cot_chopper_test.sv
`timescale 1ns/1ps
module cot_chopper_test;
  localparam int CLK_NS  = 100;
  localparam int T_OFF   = 100;
  localparam int T_DEAD  = 10;
  localparam int T_BLANK = 10;
  localparam int T_MINON = 15;
  localparam int NVEC    = 7;
  // {first pulse start, first pulse length, single late pulse (-1 none), expected drive cycles}
  localparam int VEC [NVEC][4] = '{
    '{ 3,  1, 30, 31},
    '{10,  1, -1, 15},
    '{ 9,  1, 20, 21},
    '{14,  1, -1, 15},
    '{13,  1, -1, 15},
    '{ 0, 20, -1, 15},
    '{50,  1, -1, 51}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enable = 1'b0;
  logic sense_over = 1'b0;
  logic src_hi, src_lo, snk_hi, snk_lo, chop_active;
  int   errors = 0;
  int   checks = 0;
  bit   done = 1'b0;

  always #(CLK_NS/2) clk = ~clk;

  cot_chopper #(.T_OFF(T_OFF), .T_DEAD(T_DEAD), .T_BLANK(T_BLANK), .T_MINON(T_MINON)) uut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .sense_over(sense_over),
    .src_hi(src_hi), .src_lo(src_lo), .snk_hi(snk_hi), .snk_lo(snk_lo),
    .chop_active(chop_active)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int pack_out();
    return {src_hi, src_lo, snk_hi, snk_lo, chop_active};
  endfunction

  // Restart from idle, drive the comparator per the vector, measure one chop.
  task automatic run_chop(input int p1, input int l1, input int p2, input int exp_on,
                          input string tag);
    int on_len, off_len, sync_first, sync_n, bad;
    on_len = 0; off_len = 0; sync_first = -1; sync_n = 0; bad = 0;
    enable = 1'b0; sense_over = 1'b0;
    @(negedge clk);
    @(negedge clk);
    enable = 1'b1;
    for (int j = 0; j < 400; j++) begin
      @(negedge clk);
      if (off_len == 0 && snk_lo) begin
        on_len++;
        if (chop_active !== 1'b0 || snk_hi !== 1'b0 || src_lo !== 1'b0) bad++;
        sense_over = ((j >= p1) && (j < p1 + l1)) || (j == p2);
      end else if (!snk_lo) begin
        if (snk_hi) begin
          if (sync_first < 0) sync_first = off_len;
          sync_n++;
        end
        if (chop_active !== 1'b1) bad++;
        sense_over = (off_len >= 20) && (off_len < 30);
        off_len++;
      end else begin
        break;
      end
      if (src_hi !== 1'b1) bad++;
    end
    sense_over = 1'b0;
    check(on_len == exp_on, {tag, " R3 R4 R5 drive length"}, on_len, exp_on);
    check(off_len == T_OFF + T_DEAD, {tag, " R7 R11 low-side off length"}, off_len, T_OFF + T_DEAD);
    check(sync_first == T_DEAD, {tag, " R6 recirculation start"}, sync_first, T_DEAD);
    check(sync_n == T_OFF - T_DEAD, {tag, " R6 recirculation length"}, sync_n, T_OFF - T_DEAD);
    check(bad == 0, {tag, " R8 R2 flag and pattern mismatches"}, bad, 0);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired actual=hang expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : main
    // R1 reset state with enable asserted
    enable = 1'b1;
    repeat (3) @(negedge clk);
    check(pack_out() == 0, "R1 outputs in reset", pack_out(), 0);
    enable = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(pack_out() == 0, "R1 outputs with enable low", pack_out(), 0);

    // R2 first drive cycle one clock after enable
    enable = 1'b1;
    @(negedge clk);
    check(pack_out() == 5'b10010, "R2 drive pattern", pack_out(), 5'b10010);

    for (int v = 0; v < NVEC; v++)
      run_chop(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3], $sformatf("vec%0d", v));

    // R9 enable drop in the same cycle as a trip
    enable = 1'b0; @(negedge clk); @(negedge clk);
    enable = 1'b1;
    repeat (21) @(negedge clk);
    check(snk_lo == 1'b1, "R9 still driving before drop", snk_lo, 1);
    enable = 1'b0; sense_over = 1'b1;
    #1;
    check(pack_out() == 0, "R9 immediate gate off", pack_out(), 0);
    @(negedge clk);
    check(pack_out() == 0, "R9 idle after drop", pack_out(), 0);
    sense_over = 1'b0;
    run_chop(5, 1, 20, 21, "r9_fresh_blank");

    // R9 enable drop during recirculation
    enable = 1'b0; @(negedge clk); @(negedge clk);
    enable = 1'b1;
    for (int j = 0; j < 41; j++) begin
      @(negedge clk);
      sense_over = (j == 15);
    end
    sense_over = 1'b0;
    check(snk_hi == 1'b1 && chop_active == 1'b1, "R6 in recirculation", snk_hi, 1);
    enable = 1'b0;
    #1;
    check(pack_out() == 0, "R9 gate off during recirculation", pack_out(), 0);
    @(negedge clk);
    check(chop_active == 1'b0, "R9 chop flag cleared", chop_active, 0);
    run_chop(14, 1, -1, 15, "r9_restart");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule